// File: doc/BRIEF.md
# Indexed-Opcode SPI Flash Cycle Engine

This block is a register-programmed SPI master for serial flash that runs exactly one flash cycle per launch. Software never shifts raw command bytes. It loads an eight-entry opcode menu and a table of two-bit cycle types, then picks one entry by index in the control word. The type of the chosen entry decides whether a 24-bit address follows the opcode and whether the optional data phase writes from or reads into a 64-byte data buffer.

A cycle may be preceded by a prefix opcode, such as a write enable, sent in its own chip-select frame. The main frame follows with nothing else allowed in between. A lock input freezes the menu, the type table and the prefix register, so that a trusted agent can limit which commands the rest of the system may issue. A control bit picks one of two SCK divider settings. The bus is SPI mode 0: SCK idles low, the engine samples MISO on the rising edge and changes MOSI on the falling edge.

Top module: `sfc_engine`

## Requirements
- R1: After reset CS_n is high, SCK is low and the status word (register 1) reads zero.
- R2: Register map by word address: 0 control, 1 status, 2 address, 3 menu entries 0-3, 4 menu entries 4-7 (entry i in bits 8(i mod 4)+7:8(i mod 4)), 5 type table, 6 prefix, 16-31 data buffer (byte j in word 16+j/4, bits 8(j mod 4)+7:8(j mod 4)). The opcode sent first is the menu entry named by control bits 6:4. Every byte goes out MSB first, with SCK idle low.
- R3: Entry i takes its type from type-table bits 2i+1:2i. Bit 1 of the type enables the address phase and bit 0 selects write direction: 0 read without address, 1 write without address, 2 read with address, 3 write with address. Each launch without the atomic bit produces exactly one chip-select frame.
- R4: With an addressed type, bits 23:0 of the address register follow the opcode, most significant byte first. Bits 31:24 are never sent.
- R5: Control bit 14 enables the data phase and bits 13:8 hold the byte count minus one (1 to 64 bytes). Write types send buffer bytes from byte 0 upward. Read types send 0x00 and store the received bytes into the buffer from byte 0 upward.
- R6: Writing control with bit 1 set launches a cycle. Status bit 0 is high while a cycle is pending or running. Status bit 2 (done) rises one clock after CS_n deasserts, in the same clock in which bit 0 falls. Writing 1 to status bit 2 clears it.
- R7: A launch write while a cycle is pending or running sets status bit 3 (error) and starts nothing. Writing 1 to status bit 3 clears it without touching done.
- R8: With control bit 2 set at launch, the prefix register byte is sent first as a frame of its own. CS_n then stays high for at least one SCK period, and the main frame follows.
- R9: While lock_i is high, writes to the menu, the type table and the prefix register are ignored. They take effect again once lock_i is low.
- R10: Control bit 15 selects the SCK high and low phase length: FAST_HALF clocks when set, SLOW_HALF clocks when clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Freezes menu, type table and prefix |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench goes after the phase layout of each of the four types, including an address-only cycle, an opcode-only cycle and a full 64-byte data phase. A design that mixed up the type bits, or that sent address bits 31:24, would put the wrong number of bytes or a stray byte on MOSI. A second launch during a running cycle must raise the error flag without starting a second frame. A design that dropped that guard would show an extra frame or a corrupted byte count. The bench also times done against the rise of CS_n, measures the CS_n gap after a prefix frame and the SCK high time for both rates, and checks that locked writes leave the menu and the issued opcode unchanged.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  // register word addresses
  localparam int REG_CTRL    = 0;
  localparam int REG_STAT    = 1;
  localparam int REG_ADDR    = 2;
  localparam int REG_MENU_LO = 3;
  localparam int REG_MENU_HI = 4;
  localparam int REG_TYPES   = 5;
  localparam int REG_PREFIX  = 6;
  localparam int REG_BUF     = 16;  // must be aligned to the buffer word count

  // control and status bit positions
  localparam int C_GO    = 1;
  localparam int C_ATOM  = 2;
  localparam int C_IDX   = 4;
  localparam int C_CNT   = 8;
  localparam int C_DEN   = 14;
  localparam int C_FAST  = 15;
  localparam int S_DONE  = 2;
  localparam int S_ERR   = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GAP, ST_OPC, ST_ADR, ST_DAT, ST_FIN
  } seq_state_e;

  function automatic logic [7:0] menu_pick(input logic [63:0] m, input logic [2:0] i);
    return m[8*i +: 8];
  endfunction

  function automatic logic [1:0] type_pick(input logic [15:0] t, input logic [2:0] i);
    return t[2*i +: 2];
  endfunction

  // k = 0 gives the most significant address byte
  function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [1:0] k);
    return a[23 - 8*k -: 8];
  endfunction
endpackage

// File: rtl/sfc_regs.sv
`timescale 1ns/1ps
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_BYTES = 64,
  localparam int CNT_W    = $clog2(BUF_BYTES),
  localparam int BUF_WORDS = BUF_BYTES / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              seq_busy_i,
  input  logic              seq_done_i,
  input  logic              cap_we_i,
  input  logic [CNT_W-1:0]  cap_idx_i,
  input  logic [7:0]        cap_data_i,
  input  logic [CNT_W-1:0]  buf_idx_i,
  output logic [7:0]        buf_byte_o,
  output logic              launch_o,
  output logic [2:0]        idx_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              den_o,
  output logic              fast_o,
  output logic              atom_o,
  output logic [63:0]       menu_o,
  output logic [15:0]       types_o,
  output logic [7:0]        prefix_o,
  output logic [23:0]       faddr_o
);
  logic [15:0] ctrl_q;
  logic [31:0] addr_q, menu_lo_q, menu_hi_q;
  logic [15:0] types_q;
  logic [7:0]  prefix_q;
  logic        done_q, err_q, launch_q;
  logic [7:0]  buf_q [BUF_BYTES];

  logic busy_eff, go_wr, stat_wr, in_buf;
  logic [CNT_W-1:0] bbase;
  assign busy_eff = seq_busy_i | launch_q;
  assign go_wr    = wr_i && (addr_i == ADDR_W'(REG_CTRL)) && wdata_i[C_GO];
  assign stat_wr  = wr_i && (addr_i == ADDR_W'(REG_STAT));
  assign in_buf   = (addr_i >= ADDR_W'(REG_BUF)) && (addr_i < ADDR_W'(REG_BUF + BUF_WORDS));
  assign bbase    = {addr_i[CNT_W-3:0], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; addr_q <= '0; menu_lo_q <= '0; menu_hi_q <= '0;
      types_q <= '0; prefix_q <= '0; done_q <= 1'b0; err_q <= 1'b0; launch_q <= 1'b0;
      for (int b = 0; b < BUF_BYTES; b++) buf_q[b] <= '0;
    end else begin
      launch_q <= go_wr && !busy_eff;
      if (seq_done_i)                  done_q <= 1'b1;
      else if (stat_wr && wdata_i[S_DONE]) done_q <= 1'b0;
      if (go_wr && busy_eff)           err_q <= 1'b1;
      else if (stat_wr && wdata_i[S_ERR])  err_q <= 1'b0;
      if (wr_i) begin
        if (addr_i == ADDR_W'(REG_CTRL) && !busy_eff) ctrl_q <= wdata_i[15:0];
        if (addr_i == ADDR_W'(REG_ADDR)) addr_q <= wdata_i;
        if (!lock_i) begin
          if (addr_i == ADDR_W'(REG_MENU_LO)) menu_lo_q <= wdata_i;
          if (addr_i == ADDR_W'(REG_MENU_HI)) menu_hi_q <= wdata_i;
          if (addr_i == ADDR_W'(REG_TYPES))   types_q   <= wdata_i[15:0];
          if (addr_i == ADDR_W'(REG_PREFIX))  prefix_q  <= wdata_i[7:0];
        end
        if (in_buf)
          for (int j = 0; j < 4; j++) buf_q[bbase | CNT_W'(j)] <= wdata_i[8*j +: 8];
      end
      if (cap_we_i) buf_q[cap_idx_i] <= cap_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CTRL))         rdata_o = {16'h0, ctrl_q};
    else if (addr_i == ADDR_W'(REG_STAT))    rdata_o = {28'h0, err_q, done_q, 1'b0, busy_eff};
    else if (addr_i == ADDR_W'(REG_ADDR))    rdata_o = addr_q;
    else if (addr_i == ADDR_W'(REG_MENU_LO)) rdata_o = menu_lo_q;
    else if (addr_i == ADDR_W'(REG_MENU_HI)) rdata_o = menu_hi_q;
    else if (addr_i == ADDR_W'(REG_TYPES))   rdata_o = {16'h0, types_q};
    else if (addr_i == ADDR_W'(REG_PREFIX))  rdata_o = {24'h0, prefix_q};
    else if (in_buf)
      for (int j = 0; j < 4; j++) rdata_o[8*j +: 8] = buf_q[bbase | CNT_W'(j)];
  end

  assign launch_o   = launch_q;
  assign idx_o      = ctrl_q[C_IDX +: 3];
  assign cnt_o      = ctrl_q[C_CNT +: CNT_W];
  assign den_o      = ctrl_q[C_DEN];
  assign fast_o     = ctrl_q[C_FAST];
  assign atom_o     = ctrl_q[C_ATOM];
  assign menu_o     = {menu_hi_q, menu_lo_q};
  assign types_o    = types_q;
  assign prefix_o   = prefix_q;
  assign faddr_o    = addr_q[23:0];
  assign buf_byte_o = buf_q[buf_idx_i];

  AST_LOCK_MENU_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i && wr_i && addr_i == ADDR_W'(REG_MENU_LO) |=> $stable(menu_lo_q)); // R9
  AST_LOCK_PREFIX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i && wr_i && addr_i == ADDR_W'(REG_PREFIX) |=> $stable(prefix_q)); // R9
  AST_BUSY_GO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr && seq_busy_i |=> err_q && !launch_q); // R7
  AST_LAUNCH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> !seq_busy_i); // R6
endmodule

// File: rtl/sfc_bitio.sv
`timescale 1ns/1ps
module sfc_bitio #(
  parameter int HALF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_i,
  input  logic [7:0]        tx_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [7:0]        rx_o,
  output logic              done_o
);
  logic [7:0]        sr_q, rx_q;
  logic [HALF_W-1:0] hcnt_q;
  logic [2:0]        bitc_q;
  logic              busy_q, sck_q, done_q, phase_end;

  assign phase_end = busy_q && (hcnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0; rx_q <= '0; hcnt_q <= '0; bitc_q <= '0;
      busy_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= phase_end && sck_q && (bitc_q == 3'd7);
      if (kick_i) begin
        sr_q <= tx_i; busy_q <= 1'b1; hcnt_q <= '0; bitc_q <= '0; sck_q <= 1'b0;
      end else if (busy_q) begin
        if (phase_end) begin
          hcnt_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bitc_q == 3'd7) busy_q <= 1'b0;
            else begin
              bitc_q <= bitc_q + 3'd1;
              sr_q   <= {sr_q[6:0], 1'b0};
            end
          end
        end else hcnt_q <= hcnt_q + HALF_W'(1);
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sr_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  AST_KICK_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |-> !busy_q); // R2
  AST_BYTE_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !sck_q && !busy_q); // R2
endmodule

// File: rtl/sfc_seq.sv
`timescale 1ns/1ps
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int HALF_W    = 2,
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        prefix_i,
  input  logic [1:0]        type_i,
  input  logic [23:0]       faddr_i,
  input  logic              den_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              atom_i,
  input  logic              fast_i,
  input  logic [7:0]        wbyte_i,
  output logic [CNT_W-1:0]  rd_idx_o,
  output logic              cap_we_o,
  output logic [CNT_W-1:0]  cap_idx_o,
  output logic [7:0]        cap_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              kick_o,
  output logic [7:0]        tx_o,
  output logic [HALF_W-1:0] half_o,
  input  logic              bdone_i,
  input  logic [7:0]        rx_i
);
  seq_state_e        st_q;
  logic [7:0]        opc_q, tx_q;
  logic [1:0]        typ_q;
  logic [23:0]       fa_q;
  logic              den_q, fast_q, cs_n_q, kick_q;
  logic [CNT_W-1:0]  cnt_q, k_q;
  logic [HALF_W:0]   gcnt_q;
  logic [7:0]        dtx;

  assign dtx = typ_q[0] ? wbyte_i : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; opc_q <= '0; tx_q <= '0; typ_q <= '0; fa_q <= '0;
      den_q <= 1'b0; fast_q <= 1'b0; cs_n_q <= 1'b1; kick_q <= 1'b0;
      cnt_q <= '0; k_q <= '0; gcnt_q <= '0;
    end else begin
      kick_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          opc_q <= opcode_i; typ_q <= type_i; fa_q <= faddr_i;
          den_q <= den_i; cnt_q <= cnt_i; fast_q <= fast_i;
          cs_n_q <= 1'b0; kick_q <= 1'b1; k_q <= '0;
          tx_q <= atom_i ? prefix_i : opcode_i;
          st_q <= atom_i ? ST_PRE : ST_OPC;
        end
        ST_PRE: if (bdone_i) begin
          cs_n_q <= 1'b1; gcnt_q <= '0; st_q <= ST_GAP;
        end
        ST_GAP: if (gcnt_q == {half_o, 1'b0} - (HALF_W+1)'(1)) begin
          cs_n_q <= 1'b0; tx_q <= opc_q; kick_q <= 1'b1; st_q <= ST_OPC;
        end else gcnt_q <= gcnt_q + (HALF_W+1)'(1);
        ST_OPC, ST_ADR: if (bdone_i) begin
          if (st_q == ST_OPC && typ_q[1]) begin
            tx_q <= addr_byte(fa_q, 2'd0); k_q <= '0; kick_q <= 1'b1; st_q <= ST_ADR;
          end else if (st_q == ST_ADR && k_q != CNT_W'(2)) begin
            tx_q <= addr_byte(fa_q, k_q[1:0] + 2'd1); k_q <= k_q + CNT_W'(1); kick_q <= 1'b1;
          end else if (den_q) begin
            tx_q <= dtx; k_q <= '0; kick_q <= 1'b1; st_q <= ST_DAT;
          end else begin
            cs_n_q <= 1'b1; st_q <= ST_FIN;
          end
        end
        ST_DAT: if (bdone_i) begin
          if (k_q == cnt_q) begin
            cs_n_q <= 1'b1; st_q <= ST_FIN;
          end else begin
            k_q <= k_q + CNT_W'(1); tx_q <= dtx; kick_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;  // ST_FIN
      endcase
    end
  end

  assign rd_idx_o   = (st_q == ST_DAT) ? k_q + CNT_W'(1) : '0;
  assign cap_we_o   = (st_q == ST_DAT) && bdone_i && !typ_q[0];
  assign cap_idx_o  = k_q;
  assign cap_data_o = rx_i;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
  assign cs_n_o     = cs_n_q;
  assign kick_o     = kick_q;
  assign tx_o       = tx_q;
  assign half_o     = fast_q ? HALF_W'(FAST_HALF) : HALF_W'(SLOW_HALF);

  AST_DONE_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_q && !$past(cs_n_q)); // R6
  AST_CAPTURE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we_o |-> k_q <= cnt_q && den_q); // R5
  AST_PREFIX_GAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_GAP |-> cs_n_q && !kick_q); // R8
endmodule

// File: rtl/sfc_engine.sv
`timescale 1ns/1ps
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_BYTES = 64,
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CNT_W  = $clog2(BUF_BYTES);
  localparam int HMAX   = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int HALF_W = $clog2(HMAX + 1);

  logic              launch, den, fast, atom, seq_busy, seq_done, cap_we, kick, bdone;
  logic [2:0]        idx;
  logic [CNT_W-1:0]  cnt, cap_idx, rd_idx;
  logic [63:0]       menu;
  logic [15:0]       types;
  logic [7:0]        prefix, cap_data, wbyte, tx, rx;
  logic [23:0]       faddr;
  logic [HALF_W-1:0] half;

  sfc_regs #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .seq_busy_i(seq_busy), .seq_done_i(seq_done),
    .cap_we_i(cap_we), .cap_idx_i(cap_idx), .cap_data_i(cap_data), .buf_idx_i(rd_idx),
    .buf_byte_o(wbyte), .launch_o(launch), .idx_o(idx), .cnt_o(cnt), .den_o(den),
    .fast_o(fast), .atom_o(atom), .menu_o(menu), .types_o(types), .prefix_o(prefix),
    .faddr_o(faddr));

  sfc_seq #(.CNT_W(CNT_W), .HALF_W(HALF_W), .SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(launch), .opcode_i(menu_pick(menu, idx)),
    .prefix_i(prefix), .type_i(type_pick(types, idx)), .faddr_i(faddr), .den_i(den),
    .cnt_i(cnt), .atom_i(atom), .fast_i(fast), .wbyte_i(wbyte), .rd_idx_o(rd_idx),
    .cap_we_o(cap_we), .cap_idx_o(cap_idx), .cap_data_o(cap_data), .busy_o(seq_busy),
    .done_o(seq_done), .cs_n_o(spi_cs_n), .kick_o(kick), .tx_o(tx), .half_o(half),
    .bdone_i(bdone), .rx_i(rx));

  sfc_bitio #(.HALF_W(HALF_W)) u_bitio (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .tx_i(tx), .half_i(half), .miso_i(spi_miso),
    .sck_o(spi_sck), .mosi_o(spi_mosi), .rx_o(rx), .done_o(bdone));

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_busy); // R6
endmodule

// File: tb/sfc_engine_tb.sv
`timescale 1ns/1ps
module sfc_engine_tb;
  localparam int SLOW = 3;
  localparam int FAST = 2;

  logic clk = 1'b0, rst_n = 1'b0, lock_i = 1'b0, reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  sfc_engine #(.SLOW_HALF(SLOW), .FAST_HALF(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit fin = 0;

  function automatic logic [7:0] opc(input int i);  return 8'h05 + 8'(32 * i); endfunction
  function automatic logic [7:0] wpat(input int j); return 8'h41 + 8'(29 * j); endfunction
  function automatic logic [7:0] respf(input int p); return 8'hC3 ^ 8'(37 * p); endfunction
  function automatic logic [1:0] ttype(input int i);
    case (i) 0, 6: return 2'd0; 1, 7: return 2'd1; 2, 4: return 2'd2; default: return 2'd3; endcase
  endfunction

  // flash model: records MOSI bytes, answers with respf(position in frame)
  logic [7:0] cap [512];
  int ncap = 0, nframe = 0, fpos = 0;
  logic [2:0] bitc = '0;
  logic [7:0] sh = '0, rcur;
  longint t_rise = 0, t_csup = 0, hi_len = 0, last_gap = 0;
  assign rcur = respf(fpos);
  assign spi_miso = rcur[3'd7 - bitc];
  always @(negedge spi_cs_n) begin bitc = '0; fpos = 0; nframe++; last_gap = ($time - t_csup) / 10; end
  always @(posedge spi_cs_n) t_csup = $time;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    t_rise = $time;
    if (bitc == 3'd7) begin cap[ncap % 512] = sh; ncap++; fpos++; end
    bitc = bitc + 3'd1;
  end
  always @(negedge spi_sck) hi_len = ($time - t_rise) / 10;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1; nchk++; nfail++;
      $display("FAIL R6 watchdog: got expired expected finished");
      summary(); $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); reg_addr = 6'(a); #1 v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 20000; n++) begin
      rd(1, s);
      if (!s[0] && s[2]) break;
    end
  endtask

  function automatic logic [31:0] ctrlw(input int idx, input bit de, input int cnt,
                                        input bit fast, input bit atom);
    return {16'h0, fast, de, 6'(cnt), 1'b0, 3'(idx), 1'b0, atom, 1'b1, 1'b0};
  endfunction

  // idx[42:40] de[39] cnt[38:33] fast[32] addr[31:0]
  localparam logic [42:0] VECS [8] = '{
    {3'd2, 1'b1, 6'd3,  1'b0, 32'hAB123456},
    {3'd3, 1'b1, 6'd7,  1'b1, 32'h00FEDCBA},
    {3'd0, 1'b1, 6'd1,  1'b0, 32'h00000000},
    {3'd1, 1'b0, 6'd0,  1'b1, 32'h00000000},
    {3'd5, 1'b1, 6'd63, 1'b1, 32'h00010203},
    {3'd7, 1'b1, 6'd0,  1'b0, 32'h00000000},
    {3'd6, 1'b1, 6'd0,  1'b1, 32'h00000000},
    {3'd4, 1'b0, 6'd0,  1'b0, 32'h00C0FFEE}
  };

  initial begin
    logic [31:0] v, tt;
    int base, fr0;
    repeat (3) @(negedge clk);
    chk("R1", "cs_n after reset", spi_cs_n, 1);
    chk("R1", "sck after reset", spi_sck, 0);
    rd(1, v); chk("R1", "status after reset", v, 0);
    rst_n = 1'b1;

    wr(3, {opc(3), opc(2), opc(1), opc(0)});
    wr(4, {opc(7), opc(6), opc(5), opc(4)});
    tt = '0;
    for (int i = 0; i < 8; i++) tt[2*i +: 2] = ttype(i);
    wr(5, tt);
    wr(6, 32'h06);
    rd(4, v); chk("R2", "menu high readback", v, {opc(7), opc(6), opc(5), opc(4)});

    for (int n = 0; n < 8; n++) begin
      int idx, cnt, ne;
      bit de, fast, ha, wrt;
      logic [31:0] ad;
      idx = int'(VECS[n][42:40]); de = VECS[n][39]; cnt = int'(VECS[n][38:33]);
      fast = VECS[n][32]; ad = VECS[n][31:0];
      ha = ttype(idx)[1]; wrt = ttype(idx)[0];
      for (int w = 0; w < 16; w++) wr(16 + w, {wpat(4*w+3), wpat(4*w+2), wpat(4*w+1), wpat(4*w)});
      wr(1, 32'hC);
      wr(2, ad);
      base = ncap; fr0 = nframe;
      wr(0, ctrlw(idx, de, cnt, fast, 1'b0));
      wait_done();
      ne = 1 + (ha ? 3 : 0) + (de ? cnt + 1 : 0);
      chk("R3", "frame count", nframe - fr0, 1);
      chk("R3", "bytes in frame", ncap - base, ne);
      chk("R2", "opcode from menu", cap[base % 512], opc(idx));
      if (ha) begin  // R4 bits 31:24 never sent
        chk("R4", "addr byte 2", cap[(base+1) % 512], ad[23:16]);
        chk("R4", "addr byte 1", cap[(base+2) % 512], ad[15:8]);
        chk("R4", "addr byte 0", cap[(base+3) % 512], ad[7:0]);
      end
      if (de) for (int k = 0; k <= cnt; k++)
        chk("R5", "data byte on mosi", cap[(base + 1 + (ha ? 3 : 0) + k) % 512],
            wrt ? wpat(k) : 8'h00);
      if (de && !wrt) for (int k = 0; k <= cnt; k++) begin
        rd(16 + k/4, v);
        chk("R5", "captured read byte", v[8*(k%4) +: 8], respf(1 + (ha ? 3 : 0) + k));
      end
      chk("R10", "sck high phase", hi_len, fast ? FAST : SLOW);
      rd(1, v); chk("R6", "status done idle", v[3:0], 4'b0100);
    end

    // R6: done rises one clock after cs_n rises
    wr(1, 32'hC);
    wr(0, ctrlw(1, 1'b0, 0, 1'b0, 1'b0));
    reg_addr = 6'd1;
    @(posedge spi_cs_n);
    @(negedge clk); #1 chk("R6", "status just after cs rise", reg_rdata[3:0], 4'b0001);
    @(negedge clk); #1 chk("R6", "status one clock later", reg_rdata[3:0], 4'b0100);

    // R7: launch while busy
    wr(1, 32'hC);
    wr(2, 32'h00123456);
    base = ncap; fr0 = nframe;
    wr(0, ctrlw(3, 1'b1, 15, 1'b0, 1'b0));
    repeat (10) @(negedge clk);
    wr(0, ctrlw(0, 1'b0, 0, 1'b1, 1'b0));
    rd(1, v); chk("R7", "error on busy launch", v[3], 1);
    wait_done();
    chk("R7", "no extra frame", nframe - fr0, 1);
    chk("R7", "first cycle intact", ncap - base, 20);
    chk("R7", "opcode of first cycle", cap[base % 512], opc(3));
    rd(1, v); chk("R7", "error and done held", v[3:0], 4'b1100);
    wr(1, 32'h8); rd(1, v); chk("R7", "error cleared, done kept", v[3:0], 4'b0100);
    wr(1, 32'h4); rd(1, v); chk("R6", "done cleared", v[3:0], 4'b0000);

    // R8: atomic prefix frame
    base = ncap; fr0 = nframe;
    wr(0, ctrlw(1, 1'b0, 0, 1'b0, 1'b1));
    wait_done();
    chk("R8", "two frames", nframe - fr0, 2);
    chk("R8", "prefix byte first", cap[base % 512], 8'h06);
    chk("R8", "main opcode second", cap[(base+1) % 512], opc(1));
    chk("R8", "gap at least one sck period", (last_gap >= 2*SLOW) ? 1 : 0, 1);

    // R9: lock freezes menu, types and prefix
    lock_i = 1'b1;
    wr(3, 32'h0); wr(5, 32'h0); wr(6, 32'hFF);
    rd(3, v); chk("R9", "menu low locked", v, {opc(3), opc(2), opc(1), opc(0)});
    rd(5, v); chk("R9", "types locked", v, tt);
    rd(6, v); chk("R9", "prefix locked", v, 32'h06);
    wr(1, 32'hC);
    base = ncap;
    wr(0, ctrlw(1, 1'b0, 0, 1'b1, 1'b0));
    wait_done();
    chk("R9", "issued opcode unchanged", cap[base % 512], opc(1));
    lock_i = 1'b0;
    wr(6, 32'h99); rd(6, v); chk("R9", "prefix writable after unlock", v, 32'h99);

    fin = 1;
    summary();
    $finish;
  end
endmodule